// File: doc/BRIEF.md
# Byte-wide SPI slave with write-collision detection

This block is the receiving end of a four-wire serial link. It runs on a fast system clock and brings the external serial clock, select and data-in pins into that domain through synchronizer chains. It then shifts one byte per frame in both directions at once, most significant bit first. Two configuration inputs choose the idle level of the serial clock and the transfer format. The format sets which clock edge drives the data-out pin and which edge samples the data-in pin. It also sets how the select line has to frame each byte.

The host side has a one-cycle write strobe that loads the next byte to send and a register holding the last byte received. A completion flag rises after each eighth captured bit. A collision flag rises when the host writes while the shifter is in use; that write is dropped. The host clears both flags by strobing a status read and then a data read.

Top module: `spi_slave_wcol`

## Requirements
- R1: `cfg_cpol` gives the serial clock's idle level (0 = idle low). The leading edge is the edge that leaves the idle level. All four `cfg_cpol`/`cfg_cpha` combinations move the same 8 bits, MSB first.
- R2: With `cfg_cpha`=0 the MSB of the loaded byte appears on `miso_o` once select falls. `mosi_i` is sampled on each leading edge, and the next bit is driven on each trailing edge.
- R3: With `cfg_cpha`=1 each bit is driven on a leading edge and `mosi_i` is sampled on the following trailing edge. Select may stay low across back-to-back bytes, and a host write between such bytes loads the next byte.
- R4: After 8 samples, `rx_data_o` holds the received byte with the first sampled bit in bit 7. The bit counter is back at zero.
- R5: `done_o` sets after the eighth bit is sampled and stays set until it is cleared.
- R6: With `cfg_cpha`=0, a host write while select is low sets `wcol_o` and leaves the byte being shifted out unchanged.
- R7: With `cfg_cpha`=1, a host write between a byte's first leading edge and its eighth sample sets `wcol_o` and leaves the byte being shifted out unchanged.
- R8: A `rd_stat_i` strobe followed later by a `rd_data_i` strobe clears `done_o` and `wcol_o`. A `rd_data_i` strobe with no status read before it leaves both flags set.
- R9: `miso_oe_o` is low whenever the synchronized select is high, and high while it is low.
- R10: After reset `done_o`, `wcol_o`, `miso_oe_o` and `rx_data_o` are all zero.
- R11: Raising select in the middle of a byte drops the partial byte. The next frame starts again from bit 7 and does not raise `done_o` early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Transfer format: 0 = sample on leading edge, 1 = sample on trailing edge |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| wr_en_i | input | 1 | Host write strobe for the transmit byte |
| wr_data_i | input | DATA_W | Transmit byte |
| rd_stat_i | input | 1 | Host status-read strobe |
| rd_data_i | input | 1 | Host data-read strobe |
| rx_data_o | output | DATA_W | Last received byte |
| done_o | output | 1 | Transfer-complete flag |
| wcol_o | output | 1 | Write-collision flag |

## Verification
The bench builds the block with its defaults: an 8-bit byte and two synchronizer stages. It toggles the serial clock every 8 system clocks, so the system clock is 16 times faster. That ratio leaves room for the synchronizer delay plus the registered output before each master sampling point in all four modes. Collisions are placed at chosen bit positions inside a frame. Partial frames and back-to-back phase-1 bytes under one select are driven directly. Random modes and data cover the rest.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Serial clock events in the system clock domain, already gated by select.
  typedef struct packed {
    logic lead;     // edge leaving the idle level
    logic trail;    // edge returning to the idle level
    logic ss_fall;  // select has just become active
  } spi_ev_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpha,
  input  logic              ss_s,
  input  spi_ev_t           ev,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              miso_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-2:0] rx_sr;
  logic [CNT_W-1:0]  cnt;
  logic              drive, samp;

  always_comb begin
    drive = cpha ? ev.lead : (ev.ss_fall | ev.trail);
    samp  = cpha ? ev.trail : ev.lead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr  <= '0;
      rx_sr  <= '0;
      cnt    <= '0;
      miso_o <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      rx_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (ss_s) begin
        cnt    <= '0;
        busy_o <= 1'b0;
        if (load) tx_sr <= load_data;
      end else begin
        if (drive) begin
          miso_o <= tx_sr[DATA_W-1];
          tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
          if (cpha) busy_o <= 1'b1;
        end else if (load) begin
          tx_sr <= load_data;
        end
        if (samp) begin
          rx_sr <= {rx_sr[DATA_W-3:0], mosi_s};
          if (cnt == LAST) begin
            cnt    <= '0;
            done_o <= 1'b1;
            busy_o <= 1'b0;
            rx_o   <= {rx_sr, mosi_s};
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ss_s |=> (cnt == '0)); // R11
  AST_DONE_CNT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt == '0)); // R4
endmodule

// File: rtl/spi_slv_flags.sv
module spi_slv_flags (
  input  logic clk,
  input  logic rst,
  input  logic done_ev,
  input  logic coll_ev,
  input  logic rd_stat,
  input  logic rd_data,
  output logic done_o,
  output logic wcol_o
);
  logic armed;
  logic clr;

  assign clr = rd_data & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      done_o <= 1'b0;
      wcol_o <= 1'b0;
    end else begin
      if (rd_stat)      armed <= 1'b1;
      else if (rd_data) armed <= 1'b0;
      if (done_ev)  done_o <= 1'b1;
      else if (clr) done_o <= 1'b0;
      if (coll_ev)  wcol_o <= 1'b1;
      else if (clr) wcol_o <= 1'b0;
    end
  end

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    done_ev |=> done_o); // R5
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
    coll_ev |=> wcol_o); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr && !done_ev && !coll_ev) |=> (!done_o && !wcol_o)); // R8
endmodule

// File: rtl/spi_slave_wcol.sv
module spi_slave_wcol
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              wcol_o
);
  logic [2:0] pins_s;
  logic       sck_s, ss_s, mosi_s;
  logic       sck_n, sck_n_q, ss_q;
  spi_ev_t    ev;
  logic       busy, done_ev, coll_ev, load;

  spi_slv_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({sck_i, ss_n_i, mosi_i}),
    .q_o(pins_s)
  );
  assign {sck_s, ss_s, mosi_s} = pins_s;

  assign sck_n = sck_s ^ cfg_cpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_n_q   <= 1'b0;
      ss_q      <= 1'b1;
      miso_oe_o <= 1'b0;
    end else begin
      sck_n_q   <= sck_n;
      ss_q      <= ss_s;
      miso_oe_o <= ~ss_s;
    end
  end

  always_comb begin
    ev.lead    = sck_n & ~sck_n_q & ~ss_s;
    ev.trail   = ~sck_n & sck_n_q & ~ss_s;
    ev.ss_fall = ss_q & ~ss_s;
  end

  // Phase 0: select low means the shifter is in use.
  // Phase 1: busy from the first leading edge to the eighth sample.
  assign coll_ev = wr_en_i & (cfg_cpha ? (busy | ev.lead) : ~ss_s);
  assign load    = wr_en_i & ~coll_ev;

  spi_slv_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .cpha(cfg_cpha), .ss_s(ss_s), .ev(ev),
    .mosi_s(mosi_s), .load(load), .load_data(wr_data_i),
    .miso_o(miso_o), .busy_o(busy), .done_o(done_ev), .rx_o(rx_data_o)
  );

  spi_slv_flags u_flags (
    .clk(clk), .rst(rst), .done_ev(done_ev), .coll_ev(coll_ev),
    .rd_stat(rd_stat_i), .rd_data(rd_data_i),
    .done_o(done_o), .wcol_o(wcol_o)
  );

  AST_NO_LOAD_ON_WCOL: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !cfg_cpha && !ss_s) |=> wcol_o); // R6
endmodule

// File: tb/spi_slave_wcol_tb.sv
module spi_slave_wcol_tb;
  localparam int DW = 8;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst, cpol, cpha, sck, ss_n, mosi, wr_en, rd_stat, rd_data;
  logic [DW-1:0] wr_data;
  logic miso, miso_oe, done, wcol;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_slave_wcol #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_stat_i(rd_stat), .rd_data_i(rd_data),
    .rx_data_o(rx_data), .done_o(done), .wcol_o(wcol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_clear();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cpol = pol; cpha = pha; sck = pol;
    wait_cyc(H);
  endtask

  task automatic frame_end();
    ss_n = 1'b1; sck = cpol;
    wait_cyc(H);
  endtask

  // Master side of one byte; nbits < 8 gives a partial frame.
  task automatic xfer(input logic [DW-1:0] mo, input int nbits, input int wr_bit,
                      input logic [DW-1:0] wr_val, output logic [DW-1:0] got);
    got = '0;
    if (!cpha) begin
      mosi = mo[DW-1]; ss_n = 1'b0; wait_cyc(H);
    end else if (ss_n) begin
      ss_n = 1'b0; wait_cyc(H);
    end
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        got[DW-1-i] = miso;
        sck = ~cpol; wait_cyc(H);
        if (i == wr_bit) host_write(wr_val);
        sck = cpol;
        mosi = (i < DW-1) ? mo[DW-2-i] : 1'b0;
        wait_cyc(H);
      end else begin
        sck = ~cpol; mosi = mo[DW-1-i]; wait_cyc(H);
        if (i == wr_bit) host_write(wr_val);
        got[DW-1-i] = miso;
        sck = cpol; wait_cyc(H);
      end
    end
    wait_cyc(H);
  endtask

  function automatic string fmt_req(input logic pha);
    return pha ? "R3" : "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got, a, b, mo;
    void'($urandom(32'h5EED));
    rst = 1'b1; cpol = 1'b0; cpha = 1'b0; sck = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_stat = 1'b0; rd_data = 1'b0;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    chk("R10 done", done, 0);
    chk("R10 wcol", wcol, 0);
    chk("R10 oe", miso_oe, 0);
    chk("R10 rx", rx_data, 0);

    // R1: all four modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      a = 8'hA5 ^ 8'(m * 8'h11); mo = 8'h3C + 8'(m);
      host_write(a);
      xfer(mo, DW, -1, '0, got);
      chk("R1 miso bits", got, a);
      chk("R9 oe while selected", miso_oe, 1);
      chk("R4 rx byte", rx_data, mo);
      chk("R5 done set", done, 1);
      chk("R6 no wcol", wcol, 0);
      frame_end();
      chk("R9 oe off", miso_oe, 0);
      read_clear();
      chk("R8 done cleared", done, 0);
    end

    // R6: phase-0 write while selected
    set_mode(1'b0, 1'b0);
    host_write(8'hC3);
    xfer(8'h5A, DW, 3, 8'h18, got);
    chk("R6 shifter unchanged", got, 8'hC3);
    chk("R6 wcol set", wcol, 1);
    chk("R4 rx byte", rx_data, 8'h5A);
    frame_end();
    // R8: data read without status read keeps flags
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    chk("R8 done kept", done, 1);
    chk("R8 wcol kept", wcol, 1);
    read_clear();
    chk("R8 done cleared", done, 0);
    chk("R8 wcol cleared", wcol, 0);

    // R11: aborted partial byte
    host_write(8'hF0);
    xfer(8'hFF, 3, -1, '0, got);
    chk("R11 no early done", done, 0);
    frame_end();
    host_write(8'h69);
    xfer(8'h96, DW, -1, '0, got);
    chk("R11 restart miso", got, 8'h69);
    chk("R11 restart rx", rx_data, 8'h96);
    chk("R11 done", done, 1);
    frame_end();
    read_clear();

    // R3: phase-1 back-to-back under one select
    set_mode(1'b1, 1'b1);
    host_write(8'h81);
    xfer(8'h7E, DW, -1, '0, got);
    chk("R3 first byte", got, 8'h81);
    chk("R4 first rx", rx_data, 8'h7E);
    read_clear();
    host_write(8'h42);
    chk("R3 write between bytes ok", wcol, 0);
    xfer(8'hE7, DW, -1, '0, got);
    chk("R3 second byte", got, 8'h42);
    chk("R4 second rx", rx_data, 8'hE7);
    chk("R5 second done", done, 1);
    frame_end();
    read_clear();

    // R7: phase-1 write mid-byte
    set_mode(1'b0, 1'b1);
    host_write(8'hB2);
    xfer(8'h2B, DW, 2, 8'h00, got);
    chk("R7 shifter unchanged", got, 8'hB2);
    chk("R7 wcol set", wcol, 1);
    frame_end();
    read_clear();
    chk("R8 wcol cleared", wcol, 0);

    // Random modes and data
    for (int n = 0; n < 40; n++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      set_mode(md[1], md[0]);
      a = 8'($urandom); mo = 8'($urandom);
      host_write(a);
      xfer(mo, DW, -1, '0, got);
      chk(fmt_req(md[0]), got, a);
      chk("R4 random rx", rx_data, mo);
      chk("R5 random done", done, 1);
      frame_end();
      read_clear();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule